// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical byte address by walking a two-level page hierarchy that sits in memory. A requester presents the virtual address together with the base address of the page directory for its address space. The block then reads the directory entry. That entry locates a page table, and the block reads the table entry from it. The table entry names the physical page, and the block appends the page offset to it to form the final address.

The block performs one walk at a time. It stays busy from the moment a request is accepted until the requester takes the response. Memory reads go out as single-cycle pulses on a simple read port, and the memory answers with a data-valid strobe after any latency of one cycle or more. If either entry has its present bit clear, the walk stops and the response carries a fault flag in place of an address.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: The virtual address is split into three fields. Bits [31:22] are the directory index, bits [21:12] are the table index and bits [11:0] are the byte offset. The two index fields together form the virtual page number.
- R3: The first read of a walk goes to `req_root + dir_index*4`. The sum wraps modulo 2^32, and `req_root` does not need to be aligned.
- R4: The second read goes to `{dir_entry[31:12], 12'h000} + table_index*4`. It is issued only after a present directory entry has been returned. Directory entry bits [11:1] have no effect on this address.
- R5: When both entries are present, the response has `rsp_fault`=0 and `rsp_paddr` = `{table_entry[31:12], va[11:0]}`.
- R6: A directory entry with bit 0 clear ends the walk after exactly one read. The response then has `rsp_fault`=1 and `rsp_paddr`=0.
- R7: A table entry with bit 0 clear ends the walk with `rsp_fault`=1 and `rsp_paddr`=0.
- R8: Once a request is accepted, `req_ready` stays 0 until the cycle after the response handshake (`rsp_valid` and `rsp_ready` both 1). Any `req_valid` or `req_vaddr` activity during the walk has no effect on the result.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response and its fields hold steady.
- R10: Each read is a one-cycle `mem_rd_en` pulse. The block waits for `mem_rd_valid` however long the latency is (one cycle or more), and it never reads while idle.
- R11: A `mem_rd_valid` strobe that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Physical base address of the page directory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Walk hit a non-present entry |
| rsp_paddr | output | 32 | Physical byte address (0 on fault) |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Entry read from memory |

## Verification
The walk is tried at the corners of the address fields: all-zero and all-one virtual addresses reach the first and last entry of both tables. A directory base that is not aligned, and one that wraps past 2^32, show whether the entry address comes from a true addition or from bit concatenation. Entries that carry junk in their low bits show whether anything other than bit 0 and the frame field leaks into the result. Faults are injected at each level separately, which separates an early stop after one read from a late stop after two. Latencies from one to several cycles, a stalled response, a request held high during the walk and a stray data strobe while idle test the handshakes.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [PA_W-1:0] req_root,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_fault,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            mem_rd_en,
  output logic [PA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [PA_W-1:0] mem_rd_data
);
  localparam int OFF_W = VA_W - DIR_W - TBL_W;
  localparam int ENT_SH = 2;

  typedef enum logic [2:0] {S_IDLE, S_DIR_RD, S_DIR_WT, S_TBL_RD, S_TBL_WT, S_RESP} st_t;

  st_t             st;
  logic [VA_W-1:0] va_q;
  logic [PA_W-1:0] root_q, tbase_q, paddr_q;
  logic            fault_q;

  logic [DIR_W-1:0] dir_idx;
  logic [TBL_W-1:0] tbl_idx;
  logic [OFF_W-1:0] pg_off;
  logic [PA_W-1:0]  dir_addr, tbl_addr;
  logic             present;

  assign dir_idx = va_q[VA_W-1 -: DIR_W];
  assign tbl_idx = va_q[OFF_W +: TBL_W];
  assign pg_off  = va_q[OFF_W-1:0];

  assign dir_addr = root_q  + {{(PA_W-DIR_W-ENT_SH){1'b0}}, dir_idx, {ENT_SH{1'b0}}};
  assign tbl_addr = tbase_q + {{(PA_W-TBL_W-ENT_SH){1'b0}}, tbl_idx, {ENT_SH{1'b0}}};
  assign present  = mem_rd_data[0];

  assign req_ready   = (st == S_IDLE);
  assign rsp_valid   = (st == S_RESP);
  assign rsp_fault   = fault_q;
  assign rsp_paddr   = paddr_q;
  assign mem_rd_en   = (st == S_DIR_RD) || (st == S_TBL_RD);
  assign mem_rd_addr = (st == S_TBL_RD) ? tbl_addr : dir_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      tbase_q <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          root_q  <= req_root;
          fault_q <= 1'b0;
          paddr_q <= '0;
          st      <= S_DIR_RD;
        end
        S_DIR_RD: st <= S_DIR_WT;
        S_DIR_WT: if (mem_rd_valid) begin
          if (present) begin
            tbase_q <= {mem_rd_data[PA_W-1:OFF_W], {OFF_W{1'b0}}};
            st      <= S_TBL_RD;
          end else begin
            fault_q <= 1'b1;
            st      <= S_RESP;
          end
        end
        S_TBL_RD: st <= S_TBL_WT;
        S_TBL_WT: if (mem_rd_valid) begin
          if (present) paddr_q <= {mem_rd_data[PA_W-1:OFF_W], pg_off};
          else         fault_q <= 1'b1;
          st <= S_RESP;
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_no_accept_with_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  p_read_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  p_no_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en);

  p_fault_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  p_no_read_in_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_rd_en);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0, mem_rd_valid = 1'b0;
  logic [31:0] req_vaddr = '0, req_root = '0, mem_rd_data = '0;
  logic req_ready, rsp_valid, rsp_fault, mem_rd_en;
  logic [31:0] rsp_paddr, mem_rd_addr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_root(req_root),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  typedef struct packed {
    logic [31:0] root;
    logic [31:0] va;
    logic [31:0] pde;
    logic [31:0] pte;
    logic        fault;
    logic [31:0] paddr;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{32'h0001_0000, 32'h0040_3ABC, 32'h0002_0001, 32'h0055_5003, 1'b0, 32'h0055_5ABC, 4'd1},
    '{32'h0000_1000, 32'hFFFF_FFFF, 32'hABCD_E001, 32'h1234_5FFF, 1'b0, 32'h1234_5FFF, 4'd3},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_3001, 32'h7FFF_F001, 1'b0, 32'h7FFF_F000, 4'd2},
    '{32'h8000_0000, 32'h1234_5678, 32'hFFFF_FFFE, 32'h0000_0001, 1'b1, 32'h0000_0000, 4'd1},
    '{32'h0000_2000, 32'h00C0_1004, 32'h0004_0001, 32'h0009_9000, 1'b1, 32'h0000_0000, 4'd4},
    '{32'h0000_0FF8, 32'h0080_0000, 32'h0000_5001, 32'h0000_1001, 1'b0, 32'h0000_1000, 4'd1},
    '{32'hFFFF_FFFC, 32'h0040_0000, 32'h0006_0FFF, 32'h0007_7001, 1'b0, 32'h0007_7000, 4'd6}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  task automatic walk(input vec_t v, input int hold);
    logic [31:0] a1, a2, e1, e2;
    int reads;
    int n;
    // R2/R3/R4: expected entry addresses from the field split
    e1 = v.root + {20'd0, v.va[31:22], 2'b00};
    e2 = {v.pde[31:12], 12'h000} + {20'd0, v.va[21:12], 2'b00};
    a1 = '0; a2 = '0; reads = 0; n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = v.va; req_root = v.root; rsp_ready = 1'b0;
    chk(req_ready === 1'b1, "R8 ready before accept", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_vaddr = ~v.va;   // R8: request lines keep changing during the walk
    req_root = 32'h5A5A_5A5A;
    while (!rsp_valid && n < 100) begin
      if (req_ready) chk(1'b0, "R8 ready during walk", 32'd1, 32'd0);
      if (mem_rd_en) begin
        reads++;
        if (reads == 1) a1 = mem_rd_addr; else a2 = mem_rd_addr;
        repeat (v.lat) @(negedge clk);
        mem_rd_valid = 1'b1;
        mem_rd_data = (reads == 1) ? v.pde : v.pte;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        mem_rd_data = 32'hDEAD_BEEF;
      end else begin
        @(negedge clk);
      end
      n++;
    end
    chk(rsp_valid === 1'b1, "R10 walk completes", {31'd0, rsp_valid}, 32'd1);
    chk(a1 === e1, "R3 directory entry address", a1, e1);
    if (v.pde[0]) begin
      chk(reads == 2, "R10 two reads", reads, 2);
      chk(a2 === e2, "R4 table entry address", a2, e2);
    end else begin
      chk(reads == 1, "R6 stop after directory", reads, 1);
    end
    repeat (hold) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_paddr === v.paddr, "R9 response held", rsp_paddr, v.paddr);
    end
    chk(rsp_fault === v.fault, v.fault ? (v.pde[0] ? "R7 table fault" : "R6 directory fault") : "R5 fault flag",
        {31'd0, rsp_fault}, {31'd0, v.fault});
    chk(rsp_paddr === v.paddr, v.fault ? "R6 R7 zero address on fault" : "R5 physical address",
        rsp_paddr, v.paddr);
    chk(req_ready === 1'b0, "R8 busy while response pending", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rsp_ready = 1'b0;
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R8 idle after handshake",
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk(mem_rd_en === 1'b0, "R1 mem_rd_en", {31'd0, mem_rd_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_rd_en === 1'b0, "R1 idle after reset",
        {30'd0, req_ready, mem_rd_en}, 32'd2);

    for (int i = 0; i < NV; i++) walk(VEC[i], i % 3);

    // R11: stray data strobe while idle, then a normal walk
    @(negedge clk);
    mem_rd_valid = 1'b1; mem_rd_data = 32'h0000_0000;
    @(negedge clk);
    mem_rd_valid = 1'b0;
    chk(rsp_valid === 1'b0 && req_ready === 1'b1 && mem_rd_en === 1'b0, "R11 stray strobe ignored",
        {29'd0, rsp_valid, req_ready, mem_rd_en}, 32'd2);
    walk(VEC[0], 1);

    // R2: highest directory index with lowest table index, long latency
    walk('{32'h0010_0000, 32'hFFC0_0FFF, 32'h0030_0001, 32'hFFFF_F001, 1'b0, 32'hFFFF_FFFF, 4'd8}, 2);

    finish_run();
  end
endmodule